// File: doc/BRIEF.md
# System Inactivity Stop-Clock Timer

This block watches system activity and raises a stop-clock request to the processor once the machine has been idle for a selected number of minutes. Activity comes from three sources. The first is a simple bus-cycle interface, where the block decodes a memory or I/O address. The second is a pair of level inputs for DMA and for a local bus master. The third is a vector of interrupt-request lines. Any qualifying event restarts the idle countdown from zero.

The minute time base comes from a prescaler on the clock input. Its length is the parameter `TICKS_PER_MIN`, so a simulation can use a short minute. The configuration has three inputs: a stop-clock mode enable, a 4-bit timeout, and an enable for the interrupt wake-up. The timeout takes effect only while the mode is on. Once the request is raised it stays high until the next qualifying event or the next configuration change.

Top module: `stopclk_idle_timer`

## Requirements
- R1: While `cfg_mode_en` is 0, the effective timeout is Disabled and `stop_clk_req` stays 0 one cycle after the mode is cleared and for as long as it stays cleared.
- R2: A `cfg_minutes` value of 0 means Disabled, and `stop_clk_req` is never asserted.
- R3: `cfg_minutes` is a binary count N from 1 to 15. With the mode on and no activity, `stop_clk_req` rises exactly N*`TICKS_PER_MIN` clock cycles after the clock edge that sampled the last restart.
- R4: A memory cycle (`bus_valid`=1, `bus_is_io`=0) with a 20-bit address from C0000h to C7FFFh restarts the countdown. Address C8000h does not.
- R5: A memory cycle with an address from A0000h to BFFFFh restarts the countdown. Address 9FFFFh does not.
- R6: An I/O cycle (`bus_is_io`=1) whose port, `bus_addr[15:0]`, lies from 0001h to 3FFFh restarts the countdown. Ports 0000h and 4000h do not.
- R7: A high level on `dma_active` or on `lbm_active` restarts the countdown.
- R8: A high level on an `irq` line with index 3, 4, 5, 7, 9, 10, 11, 12 or 15 restarts the countdown, but only while `cfg_irq_wake` is 1. The other lines never restart it.
- R9: After reset `stop_clk_req` is 0 and the effective configuration is Disabled.
- R10: Once asserted, `stop_clk_req` stays high until a qualifying event is sampled. That event clears the request at the same edge and restarts the count from zero.
- R11: A change of the effective timeout clears `stop_clk_req` at the next edge and restarts the count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode_en | input | 1 | Stop-clock mode enable |
| cfg_minutes | input | 4 | Timeout in minutes, 0 = Disabled |
| cfg_irq_wake | input | 1 | Lets the selected interrupt lines restart the count |
| bus_valid | input | 1 | A bus cycle is present this clock |
| bus_is_io | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| bus_addr | input | 20 | Bus cycle address |
| dma_active | input | 1 | DMA activity level |
| lbm_active | input | 1 | Local bus master activity level |
| irq | input | 16 | Interrupt request lines |
| stop_clk_req | output | 1 | Stop-clock request to the processor |

## Verification
The main function is tried with three kinds of input pattern.

- **Idle runs of 1, 3 and 15 minutes.** These check that the request rises on the exact clock edge and not one minute early or late.
- **Events applied while the request is high.** The patterns are addresses just inside and just outside each window edge, I/O ports 0000h, 3FFFh and 4000h, each interrupt class with the wake-up option on and off, and DMA and bus-master levels. A restarting event drops the request and re-times a full minute. An ignored event leaves the request high.
- **Configuration changes.** Changes of the timeout and of the mode enable show that a new setting restarts the count and that a cleared mode or a Disabled setting keeps the output low.

// File: rtl/idle_pkg.sv
package idle_pkg;

    localparam int ADDR_W = 20;
    localparam int PORT_W = 16;
    localparam int IRQ_N  = 16;
    localparam int MIN_W  = 4;

    // interrupt lines allowed to restart the count: 15,12,11,10,9,7,5,4,3
    localparam logic [IRQ_N-1:0] IRQ_WAKE_MASK = 16'h9EB8;

    localparam logic [ADDR_W-1:0] VGA_MEM_LO = 20'hA0000;
    localparam logic [ADDR_W-1:0] VGA_MEM_HI = 20'hBFFFF;
    localparam logic [ADDR_W-1:0] VID_ROM_LO = 20'hC0000;
    localparam logic [ADDR_W-1:0] VID_ROM_HI = 20'hC7FFF;
    localparam logic [PORT_W-1:0] PORT_HI    = 16'h3FFF;

    typedef struct packed {
        logic              valid;
        logic              is_io;
        logic [ADDR_W-1:0] addr;
    } bus_cyc_t;

    typedef struct packed {
        logic             side_dma;
        logic             side_lbm;
        logic             irq_any;
        logic             bus_hit;
    } wake_src_t;

    function automatic logic in_video_mem(input logic [ADDR_W-1:0] a);
        return (a >= VGA_MEM_LO) && (a <= VGA_MEM_HI);
    endfunction

    function automatic logic in_video_rom(input logic [ADDR_W-1:0] a);
        return (a >= VID_ROM_LO) && (a <= VID_ROM_HI);
    endfunction

    function automatic logic in_port_range(input logic [PORT_W-1:0] p);
        return (p != '0) && (p <= PORT_HI);
    endfunction

    // effective minutes: the mode enable gates the timeout to Disabled
    function automatic logic [MIN_W-1:0] eff_minutes(input logic mode_en,
                                                     input logic [MIN_W-1:0] m);
        return mode_en ? m : '0;
    endfunction

endpackage

// File: rtl/idle_event_decode.sv
module idle_event_decode
    import idle_pkg::*;
(
    input  bus_cyc_t         bus,
    input  logic             dma_active,
    input  logic             lbm_active,
    input  logic [IRQ_N-1:0] irq,
    input  logic             irq_wake_en,
    output wake_src_t        src,
    output logic             activity
);
    logic [IRQ_N-1:0] irq_gated;

    for (genvar i = 0; i < IRQ_N; i++) begin : g_irq
        if (IRQ_WAKE_MASK[i]) begin : g_on
            assign irq_gated[i] = irq[i] & irq_wake_en;
        end else begin : g_off
            assign irq_gated[i] = 1'b0;
        end
    end

    logic mem_hit, io_hit;

    always_comb begin
        mem_hit = bus.valid && !bus.is_io &&
                  (in_video_mem(bus.addr) || in_video_rom(bus.addr));
        io_hit  = bus.valid && bus.is_io && in_port_range(bus.addr[PORT_W-1:0]);
        src.bus_hit  = mem_hit | io_hit;
        src.irq_any  = |irq_gated;
        src.side_dma = dma_active;
        src.side_lbm = lbm_active;
        activity     = src.bus_hit | src.irq_any | src.side_dma | src.side_lbm;
    end

endmodule

// File: rtl/idle_minute_prescaler.sv
module idle_minute_prescaler #(
    parameter int unsigned TICKS_PER_MIN = 32'd15_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic minute_tick
);
    localparam int CW = (TICKS_PER_MIN < 2) ? 1 : $clog2(TICKS_PER_MIN);
    localparam logic [CW-1:0] LAST = CW'(TICKS_PER_MIN - 1);

    logic [CW-1:0] cnt;

    assign minute_tick = (cnt == LAST) && !restart;

    always_ff @(posedge clk) begin
        if (rst || restart || minute_tick) cnt <= '0;
        else                               cnt <= cnt + 1'b1;
    end

    AST_PRESCALE_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);                                                    // R3
    AST_RESTART_ZEROES: assert property (@(posedge clk) disable iff (rst)
        restart |=> (cnt == '0));                                        // R10

endmodule

// File: rtl/idle_minute_counter.sv
module idle_minute_counter
    import idle_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             minute_tick,
    input  logic [MIN_W-1:0] limit,
    output logic             req
);
    logic [MIN_W-1:0] mins;

    always_ff @(posedge clk) begin
        if (rst || restart || limit == '0) begin
            mins <= '0;
            req  <= 1'b0;
        end else if (minute_tick && !req) begin
            mins <= mins + 1'b1;
            if (mins + 1'b1 == limit) req <= 1'b1;
        end
    end

    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (rst)
        restart |=> !req);                                               // R10
    AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (req && !restart && limit != '0) |=> req);                       // R10
    AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        $rose(req) |-> $past(minute_tick));                              // R3
    AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (rst)
        (limit == '0) |=> !req);                                         // R2

endmodule

// File: rtl/stopclk_idle_timer.sv
module stopclk_idle_timer
    import idle_pkg::*;
#(
    parameter int unsigned TICKS_PER_MIN = 32'd15_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_mode_en,
    input  logic [MIN_W-1:0]  cfg_minutes,
    input  logic              cfg_irq_wake,
    input  logic              bus_valid,
    input  logic              bus_is_io,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              dma_active,
    input  logic              lbm_active,
    input  logic [IRQ_N-1:0]  irq,
    output logic              stop_clk_req
);
    bus_cyc_t         bus;
    wake_src_t        src;
    logic             activity;
    logic [MIN_W-1:0] limit, limit_q;
    logic             cfg_changed, restart, minute_tick;

    assign bus = '{valid: bus_valid, is_io: bus_is_io, addr: bus_addr};

    idle_event_decode u_decode (
        .bus         (bus),
        .dma_active  (dma_active),
        .lbm_active  (lbm_active),
        .irq         (irq),
        .irq_wake_en (cfg_irq_wake),
        .src         (src),
        .activity    (activity)
    );

    assign limit = eff_minutes(cfg_mode_en, cfg_minutes);

    always_ff @(posedge clk) begin
        if (rst) limit_q <= '0;
        else     limit_q <= limit;
    end

    assign cfg_changed = (limit != limit_q);
    assign restart     = activity | cfg_changed;

    idle_minute_prescaler #(.TICKS_PER_MIN(TICKS_PER_MIN)) u_prescale (
        .clk         (clk),
        .rst         (rst),
        .restart     (restart),
        .minute_tick (minute_tick)
    );

    idle_minute_counter u_count (
        .clk         (clk),
        .rst         (rst),
        .restart     (restart),
        .minute_tick (minute_tick),
        .limit       (limit),
        .req         (stop_clk_req)
    );

    AST_MODE_OFF_LOW: assert property (@(posedge clk) disable iff (rst)
        !cfg_mode_en |=> !stop_clk_req);                                 // R1
    AST_CFG_CHANGE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        cfg_changed |=> !stop_clk_req);                                  // R11
    AST_RESET_LOW: assert property (@(posedge clk)
        rst |=> !stop_clk_req);                                          // R9

endmodule

// File: tb/stopclk_idle_timer_test.sv
module stopclk_idle_timer_test;
    localparam int TPM = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_mode_en = 1'b0;
    logic [3:0]  cfg_minutes = 4'd0;
    logic        cfg_irq_wake = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_is_io = 1'b0;
    logic [19:0] bus_addr = 20'h0;
    logic        dma_active = 1'b0;
    logic        lbm_active = 1'b0;
    logic [15:0] irq = 16'h0;
    logic        stop_clk_req;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    stopclk_idle_timer #(.TICKS_PER_MIN(TPM)) uut (
        .clk(clk), .rst(rst), .cfg_mode_en(cfg_mode_en), .cfg_minutes(cfg_minutes),
        .cfg_irq_wake(cfg_irq_wake), .bus_valid(bus_valid), .bus_is_io(bus_is_io),
        .bus_addr(bus_addr), .dma_active(dma_active), .lbm_active(lbm_active),
        .irq(irq), .stop_clk_req(stop_clk_req)
    );

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: stop_clk_req=%b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // after a restart sampled at edge E0 (bench just past the next negedge),
    // the request is low at E0+n-1 and high at E0+n
    task automatic expect_rise(input int n, input string tag);
        repeat (n - 1) @(posedge clk);
        #1 chk(stop_clk_req, 1'b0, {tag, " early"});
        @(posedge clk);
        #1 chk(stop_clk_req, 1'b1, {tag, " rise"});
    endtask

    task automatic set_cfg(input logic en, input logic [3:0] m);
        @(negedge clk);
        cfg_mode_en = en;
        cfg_minutes = m;
        @(negedge clk);
    endtask

    task automatic pulse_dma();
        @(negedge clk); dma_active = 1'b1;
        @(negedge clk); dma_active = 1'b0;
    endtask

    // request is high on entry; the event either restarts or is ignored
    task automatic probe(input int kind, input logic io, input logic [19:0] a,
                         input int line, input logic restarts, input string tag);
        @(negedge clk);
        case (kind)
            0: begin bus_valid = 1'b1; bus_is_io = io; bus_addr = a; end
            1: irq[line] = 1'b1;
            2: dma_active = 1'b1;
            default: lbm_active = 1'b1;
        endcase
        @(negedge clk);
        bus_valid = 1'b0; irq = '0; dma_active = 1'b0; lbm_active = 1'b0;
        if (restarts) begin
            chk(stop_clk_req, 1'b0, {tag, " cleared"});
            expect_rise(TPM, tag);
        end else begin
            chk(stop_clk_req, 1'b1, {tag, " ignored"});
        end
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        #1 chk(stop_clk_req, 1'b0, "R9 in reset");
        @(negedge clk); rst = 1'b0;
        repeat (3 * TPM) @(posedge clk);
        #1 chk(stop_clk_req, 1'b0, "R9 default disabled");
    endtask

    task automatic t_timing();
        set_cfg(1'b1, 4'd1);  expect_rise(1 * TPM, "R3 1 min");
        set_cfg(1'b1, 4'd3);  expect_rise(3 * TPM, "R3 3 min");
        set_cfg(1'b1, 4'd15); expect_rise(15 * TPM, "R3 15 min");
        pulse_dma();          expect_rise(15 * TPM, "R10 restart from zero");
        repeat (40) @(posedge clk);
        #1 chk(stop_clk_req, 1'b1, "R10 held high");
    endtask

    task automatic t_windows();
        set_cfg(1'b1, 4'd1); expect_rise(TPM, "R11 setup");
        probe(0, 1'b0, 20'hC0000, 0, 1'b1, "R4 C0000");
        probe(0, 1'b0, 20'hC7FFF, 0, 1'b1, "R4 C7FFF");
        probe(0, 1'b0, 20'hC8000, 0, 1'b0, "R4 C8000");
        probe(0, 1'b0, 20'hA0000, 0, 1'b1, "R5 A0000");
        probe(0, 1'b0, 20'hBFFFF, 0, 1'b1, "R5 BFFFF");
        probe(0, 1'b0, 20'h9FFFF, 0, 1'b0, "R5 9FFFF");
        probe(0, 1'b1, 20'h00001, 0, 1'b1, "R6 port 0001");
        probe(0, 1'b1, 20'h03FFF, 0, 1'b1, "R6 port 3FFF");
        probe(0, 1'b1, 20'h00000, 0, 1'b0, "R6 port 0000");
        probe(0, 1'b1, 20'h04000, 0, 1'b0, "R6 port 4000");
        probe(0, 1'b1, 20'hA0000, 0, 1'b0, "R6 io not memory");
        probe(2, 1'b0, 20'h0, 0, 1'b1, "R7 dma");
        probe(3, 1'b0, 20'h0, 0, 1'b1, "R7 lbm");
    endtask

    task automatic t_irq();
        cfg_irq_wake = 1'b0;
        probe(1, 1'b0, 20'h0, 3, 1'b0, "R8 irq3 wake off");
        probe(1, 1'b0, 20'h0, 15, 1'b0, "R8 irq15 wake off");
        cfg_irq_wake = 1'b1;
        for (int i = 0; i < 16; i++) begin
            logic allowed;
            allowed = (i == 3 || i == 4 || i == 5 || i == 7 || i == 9 ||
                       i == 10 || i == 11 || i == 12 || i == 15);
            probe(1, 1'b0, 20'h0, i, allowed, $sformatf("R8 irq%0d", i));
        end
        cfg_irq_wake = 1'b0;
    endtask

    task automatic t_config();
        @(negedge clk); cfg_minutes = 4'd2;
        @(negedge clk);
        chk(stop_clk_req, 1'b0, "R11 change clears");
        expect_rise(2 * TPM, "R11 new timeout");
        set_cfg(1'b0, 4'd2);
        chk(stop_clk_req, 1'b0, "R1 mode off clears");
        repeat (4 * TPM) @(posedge clk);
        #1 chk(stop_clk_req, 1'b0, "R1 mode off stays low");
        set_cfg(1'b1, 4'd0);
        repeat (4 * TPM) @(posedge clk);
        #1 chk(stop_clk_req, 1'b0, "R2 disabled stays low");
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_timing();
                t_windows();
                t_irq();
                t_config();
            end
            begin
                repeat (150000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: run did not finish, actual hung expected done");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule